// File: doc/BRIEF.md
# Interleaving Section Address Mapper

This block turns a 32-bit system request address into three things: which memory controller serves it, which address space on that controller it belongs to, and the physical address to issue. The decision comes from a small bank of programmable mapping sections. Each section claims an aligned window of the system map, selected by the top address byte and a size code. It relocates that window by masking and OR-ing a new top byte.

A section can also split its window across two controllers in fixed-size chunks. In that case one low system address bit picks the controller. That bit is then removed from the address, and every bit above it slides down one place before the relocation step. Software programs each section through a one-word write port. Requests arrive on a valid/ready handshake and are answered one cycle later on a second valid/ready handshake. A request that matches no enabled section comes back flagged as an error.

Top module: `ilv_addr_mapper`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, and every section is disabled, so any request is answered with an error.
- R2: A section matches when its map code is not 0 and (addr[31:24] AND (0xFF shifted left by the size code)) equals the section's 8-bit system base. The section word layout is: system base [31:24], size code [22:20], interleave code [19:18], address space [17:16], map code [9:8] and physical base [7:0].
- R3: When several enabled sections match, the one with the lowest index decides the translation.
- R4: A request with no match returns `rsp_err`=1, `rsp_ctrl_sel`=00, `rsp_space`=0 and `rsp_paddr`=0.
- R5: A section without interleaving produces the physical address {(addr[31:24] AND (2^size−1)) OR base, addr[23:0]}.
- R6: In an interleaved section, the interleave code picks the selector bit: code 1 uses bit 7 (128-byte chunks), code 2 uses bit 8 (256-byte) and code 3 uses bit 9 (512-byte). A selector value of 0 picks the first controller and 1 picks the second.
- R7: In an interleaved section, the selector bit is removed. Bits above it move down one place, bit 31 becomes 0, and the lower bits stay as they are. The R5 relocation is then applied to the result. For example, section {base 0x80, size 5, code 1, map 3} maps 0x99AE_37F0 to 0x0CD7_1BF0 on the second controller.
- R8: The map code sets the controller select (`rsp_ctrl_sel` bit 0 = first controller, bit 1 = second). Code 1 means first only and code 2 means second only. Code 3 interleaves when the interleave code is nonzero. With interleave code 0 it behaves as first only, with no bit removed. Code 0 disables the section.
- R9: A request accepted on a clock edge is answered with `rsp_valid`=1 after that edge. The response holds unchanged while `rsp_ready` is 0.
- R10: `req_ready` is 0 exactly when a response is pending and `rsp_ready` is 0.
- R11: A section write takes effect for requests accepted on later edges. A request accepted on the same edge as the write uses the old contents.
- R12: `rsp_space` returns the address space field of the matching section.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Section write strobe |
| cfg_idx | input | 2 | Index of the section to write |
| cfg_wdata | input | 32 | New section word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_addr | input | 32 | System address |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Downstream takes the response |
| rsp_ctrl_sel | output | 2 | One-hot controller select, 00 on error |
| rsp_space | output | 2 | Address space of the matching section |
| rsp_paddr | output | 32 | Physical address |
| rsp_err | output | 1 | No enabled section matched |

## Verification
The bench uses the default build: four sections, 32-bit addresses and a selector base bit of 7. With four sections it can set up two overlapping windows for the priority case while keeping the chunk-interleaved section and the second-controller-only section from the worked example programmed. With the base bit at 7, all three chunk granularities (bits 7, 8 and 9) can be tested by rewriting one section. A reference model in the bench removes the selector bit one bit position at a time and compares every response field against the design.

// File: rtl/ilv_map_pkg.sv
// Package: ilv_map_pkg
// Shared section-word layout, code values and mask helpers for the
// interleaving address mapper. Assumes a 32-bit section word.
package ilv_map_pkg;

    typedef enum logic [1:0] {
        MAP_OFF    = 2'd0,
        MAP_FIRST  = 2'd1,
        MAP_SECOND = 2'd2,
        MAP_BOTH   = 2'd3
    } map_code_e;

    typedef enum logic [1:0] {
        ILV_NONE = 2'd0,
        ILV_C128 = 2'd1,
        ILV_C256 = 2'd2,
        ILV_C512 = 2'd3
    } ilv_code_e;

    // One mapping section as it sits in its configuration word.
    typedef struct packed {
        logic [7:0] sys_base;   // [31:24]
        logic       rsv_a;      // [23]
        logic [2:0] size;       // [22:20]
        ilv_code_e  ilv;        // [19:18]
        logic [1:0] space;      // [17:16]
        logic [5:0] rsv_b;      // [15:10]
        map_code_e  map;        // [9:8]
        logic [7:0] phys_base;  // [7:0]
    } sect_cfg_t;

    localparam int SECT_W = $bits(sect_cfg_t);

    // Mask applied to the top address byte when testing a window match.
    function automatic logic [7:0] match_mask(input logic [2:0] size);
        return 8'hFF << size;
    endfunction

    // Mask that keeps the top-byte bits that fall inside the window.
    function automatic logic [7:0] keep_mask(input logic [2:0] size);
        return ~(8'hFF << size);
    endfunction

endpackage

// File: rtl/ilv_sect_regs.sv
// Module: ilv_sect_regs
// Holds the programmable section words. One write port updates one
// section per cycle; an index past the last section is dropped.
// Assumes the caller presents a fully formed section word.
module ilv_sect_regs
    import ilv_map_pkg::*;
#(
    parameter int NUM_SECT = 4,
    parameter int IDX_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  sect_cfg_t                  wr_data,
    output sect_cfg_t [NUM_SECT-1:0]   sect_q
);

    for (genvar g = 0; g < NUM_SECT; g++) begin : g_entry
        sect_cfg_t entry_q;

        // Store this section's word; reset leaves it disabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                entry_q <= wr_data;
            end
        end

        assign sect_q[g] = entry_q;

        // A write to this section is visible on the following cycle.
        p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_idx == IDX_W'(g))) |=> (entry_q == $past(wr_data)));
    end

endmodule

// File: rtl/ilv_sect_match.sv
// Module: ilv_sect_match
// Tests the top address byte against every enabled section and picks
// the lowest-numbered section that matches. Purely combinational.
module ilv_sect_match
    import ilv_map_pkg::*;
#(
    parameter int NUM_SECT = 4
) (
    input  logic [7:0]               addr_top,
    input  sect_cfg_t [NUM_SECT-1:0] sect_cfg,
    output logic                     hit_any,
    output sect_cfg_t                win_cfg
);

    logic [NUM_SECT-1:0] hit_vec;

    for (genvar g = 0; g < NUM_SECT; g++) begin : g_hit
        // Window compare for one section; disabled sections never match.
        always_comb begin
            hit_vec[g] = (sect_cfg[g].map != MAP_OFF) &&
                         ((addr_top & match_mask(sect_cfg[g].size)) == sect_cfg[g].sys_base);
        end
    end

    // Priority pick: scan from the top so the lowest index overwrites last.
    always_comb begin
        win_cfg = '0;
        for (int i = NUM_SECT - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                win_cfg = sect_cfg[i];
            end
        end
        hit_any = |hit_vec;
    end

endmodule

// File: rtl/ilv_xlate.sv
// Module: ilv_xlate
// Forms controller select, address space and physical address from a
// system address and the winning section. Assumes ADDR_W >= 8 and that
// SEL_BASE + 3 stays below ADDR_W - 8 so the selector sits under the top byte.
module ilv_xlate
    import ilv_map_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SEL_BASE = 7
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              hit,
    input  sect_cfg_t         cfg,
    output logic [1:0]        ctrl_sel,
    output logic [1:0]        space,
    output logic [ADDR_W-1:0] paddr,
    output logic              err
);

    localparam int TOP_LSB = ADDR_W - 8;

    logic              split;
    int unsigned       sel_pos;
    logic              sel_bit;
    logic [ADDR_W-1:0] low_keep;
    logic [ADDR_W-1:0] squeezed;

    // Locate the chunk selector and squeeze it out of the address.
    always_comb begin
        split    = (cfg.map == MAP_BOTH) && (cfg.ilv != ILV_NONE);
        sel_pos  = SEL_BASE + {30'd0, cfg.ilv} - 1;
        sel_bit  = addr[sel_pos];
        low_keep = (ADDR_W'(1) << sel_pos) - ADDR_W'(1);
        if (split) begin
            squeezed = ((addr >> (sel_pos + 1)) << sel_pos) | (addr & low_keep);
        end else begin
            squeezed = addr;
        end
    end

    // Relocate the top byte and drive the result fields.
    always_comb begin
        ctrl_sel = 2'b00;
        space    = 2'd0;
        paddr    = '0;
        err      = !hit;
        if (hit) begin
            space = cfg.space;
            paddr = {(squeezed[ADDR_W-1:TOP_LSB] & keep_mask(cfg.size)) | cfg.phys_base,
                     squeezed[TOP_LSB-1:0]};
            unique case (cfg.map)
                MAP_FIRST:  ctrl_sel = 2'b01;
                MAP_SECOND: ctrl_sel = 2'b10;
                MAP_BOTH:   ctrl_sel = (split && sel_bit) ? 2'b10 : 2'b01;
                default:    ctrl_sel = 2'b00;
            endcase
        end
    end

endmodule

// File: rtl/ilv_addr_mapper.sv
// Module: ilv_addr_mapper
// Top of the section-based address mapper. Requests are translated in
// one cycle and held in an output stage that honours back-pressure.
// Assumes cfg_wdata uses the section word layout of ilv_map_pkg.
module ilv_addr_mapper
    import ilv_map_pkg::*;
#(
    parameter int NUM_SECT = 4,
    parameter int ADDR_W   = 32,
    parameter int SEL_BASE = 7,
    localparam int IDX_W   = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [SECT_W-1:0] cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_ctrl_sel,
    output logic [1:0]        rsp_space,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_err
);

    sect_cfg_t [NUM_SECT-1:0] sect_q;
    sect_cfg_t                win_cfg;
    logic                     hit_any;
    logic [1:0]               x_sel;
    logic [1:0]               x_space;
    logic [ADDR_W-1:0]        x_paddr;
    logic                     x_err;
    logic                     accept;

    ilv_sect_regs #(
        .NUM_SECT (NUM_SECT),
        .IDX_W    (IDX_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_data (sect_cfg_t'(cfg_wdata)),
        .sect_q  (sect_q)
    );

    ilv_sect_match #(
        .NUM_SECT (NUM_SECT)
    ) u_match (
        .addr_top (req_addr[ADDR_W-1 -: 8]),
        .sect_cfg (sect_q),
        .hit_any  (hit_any),
        .win_cfg  (win_cfg)
    );

    ilv_xlate #(
        .ADDR_W   (ADDR_W),
        .SEL_BASE (SEL_BASE)
    ) u_xlate (
        .addr     (req_addr),
        .hit      (hit_any),
        .cfg      (win_cfg),
        .ctrl_sel (x_sel),
        .space    (x_space),
        .paddr    (x_paddr),
        .err      (x_err)
    );

    // Accept when the output stage is empty or draining this cycle.
    always_comb begin
        req_ready = !rsp_valid || rsp_ready;
        accept    = req_valid && req_ready;
    end

    // Output stage: load on accept, clear once taken with nothing new.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_ctrl_sel <= 2'b00;
            rsp_space    <= 2'd0;
            rsp_paddr    <= '0;
            rsp_err      <= 1'b0;
        end else if (accept) begin
            rsp_valid    <= 1'b1;
            rsp_ctrl_sel <= x_sel;
            rsp_space    <= x_space;
            rsp_paddr    <= x_paddr;
            rsp_err      <= x_err;
        end else if (rsp_ready) begin
            rsp_valid    <= 1'b0;
        end
    end

    p_accept_answers_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) &&
                                       $stable(rsp_ctrl_sel) && $stable(rsp_err) &&
                                       $stable(rsp_space)));

    p_stall_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |-> !req_ready);

    p_err_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_ctrl_sel == 2'b00 && rsp_paddr == '0));

    p_sel_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |-> ($countones(rsp_ctrl_sel) == 1));

endmodule

// File: tb/test_ilv_addr_mapper.sv
module test_ilv_addr_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = 32'd0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [1:0]  rsp_ctrl_sel;
    logic [1:0]  rsp_space;
    logic [31:0] rsp_paddr;
    logic        rsp_err;

    int total = 0;
    int bad   = 0;
    logic [31:0] shadow [4];

    always #10 clk = ~clk;

    ilv_addr_mapper i_ilv_addr_mapper (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_idx      (cfg_idx),
        .cfg_wdata    (cfg_wdata),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .rsp_valid    (rsp_valid),
        .rsp_ready    (rsp_ready),
        .rsp_ctrl_sel (rsp_ctrl_sel),
        .rsp_space    (rsp_space),
        .rsp_paddr    (rsp_paddr),
        .rsp_err      (rsp_err)
    );

    function automatic logic [31:0] mk(input logic [7:0] base, input logic [2:0] sz,
                                       input logic [1:0] il, input logic [1:0] sp,
                                       input logic [1:0] mp, input logic [7:0] pb);
        return {base, 1'b0, sz, il, sp, 6'd0, mp, pb};
    endfunction

    // Reference translation built from the requirements, bit by bit.
    function automatic logic [36:0] model(input logic [31:0] a);
        logic [31:0] t;
        logic [31:0] c;
        logic [1:0]  sel;
        logic        found;
        int          b;
        logic [7:0]  km;
        found = 1'b0;
        sel = 2'b00;
        t = 32'd0;
        c = 32'd0;
        for (int k = 0; k < 4; k++) begin
            if (!found && shadow[k][9:8] != 2'd0 &&
                ((a[31:24] & (8'hFF << shadow[k][22:20])) == shadow[k][31:24])) begin
                found = 1'b1;
                c = shadow[k];
            end
        end
        if (!found) return {1'b1, 2'b00, 2'd0, 32'd0};
        t = a;
        if (c[9:8] == 2'd1) sel = 2'b01;
        else if (c[9:8] == 2'd2) sel = 2'b10;
        else if (c[19:18] == 2'd0) sel = 2'b01;
        else begin
            b = 6 + int'(c[19:18]);
            sel = a[b] ? 2'b10 : 2'b01;
            for (int j = 0; j < 31; j++) t[j] = (j < b) ? a[j] : a[j+1];
            t[31] = 1'b0;
        end
        km = (8'd1 << c[22:20]) - 8'd1;
        return {1'b0, sel, c[17:16], (t[31:24] & km) | c[7:0], t[23:0]};
    endfunction

    task automatic check(input string tag, input logic [36:0] act, input logic [36:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_sect(input int idx, input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        shadow[idx] = w;
    endtask

    task automatic send(input logic [31:0] a, output logic [36:0] r);
        @(negedge clk);
        req_addr = a; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        r = {rsp_err, rsp_ctrl_sel, rsp_space, rsp_paddr};
    endtask

    task automatic send_chk(input string tag, input logic [31:0] a);
        logic [36:0] r;
        send(a, r);
        check(tag, r, model(a));
    endtask

    task automatic t_reset;
        logic [36:0] r;
        check("R1 idle after reset", {35'd0, rsp_valid, req_ready}, {35'd0, 1'b0, 1'b1});
        send(32'h8000_0000, r);
        check("R1 R4 unprogrammed miss", r, {1'b1, 2'b00, 2'd0, 32'd0});
    endtask

    task automatic t_example;
        logic [36:0] r;
        write_sect(0, mk(8'h80, 3'd5, 2'd1, 2'd0, 2'd3, 8'h00));
        write_sect(1, mk(8'hA0, 3'd4, 2'd0, 2'd0, 2'd2, 8'h10));
        send(32'h99AE_37F0, r);
        check("R7 worked example", r, {1'b0, 2'b10, 2'd0, 32'h0CD7_1BF0});
        send(32'h8000_0070, r);
        check("R6 selector 0 first", r, {1'b0, 2'b01, 2'd0, 32'h0000_0070});
        send(32'hA123_4567, r);
        check("R5 R8 second only", r, {1'b0, 2'b10, 2'd0, 32'h1123_4567});
        send_chk("R2 window edge", 32'hAFFF_FFFF);
        send_chk("R2 just past window", 32'hB000_0000);
    endtask

    task automatic t_granule;
        logic [36:0] r;
        write_sect(0, mk(8'h80, 3'd5, 2'd2, 2'd0, 2'd3, 8'h00));
        send(32'h8000_0100, r);
        check("R6 256-byte selector", r, {1'b0, 2'b10, 2'd0, 32'h0000_0000});
        send_chk("R7 256-byte squeeze", 32'h9F12_35AB);
        write_sect(0, mk(8'h80, 3'd5, 2'd3, 2'd0, 2'd3, 8'h20));
        send(32'h8000_0300, r);
        check("R6 512-byte selector", r, {1'b0, 2'b10, 2'd0, 32'h2000_0100});
        send_chk("R7 512-byte squeeze", 32'h9BCD_EDFF);
        write_sect(0, mk(8'h80, 3'd5, 2'd0, 2'd0, 2'd3, 8'h00));
        send(32'h8000_0180, r);
        check("R8 map3 no interleave", r, {1'b0, 2'b01, 2'd0, 32'h0000_0180});
    endtask

    task automatic t_priority;
        logic [36:0] r;
        write_sect(2, mk(8'h40, 3'd6, 2'd0, 2'd1, 2'd1, 8'h00));
        write_sect(3, mk(8'h40, 3'd4, 2'd0, 2'd2, 2'd2, 8'h50));
        send(32'h4500_0000, r);
        check("R3 R12 lower index wins", r, {1'b0, 2'b01, 2'd1, 32'h0500_0000});
        write_sect(2, mk(8'h40, 3'd6, 2'd0, 2'd1, 2'd0, 8'h00));
        send(32'h4500_0000, r);
        check("R8 R12 disabled skipped", r, {1'b0, 2'b10, 2'd2, 32'h5500_0000});
        write_sect(3, mk(8'h40, 3'd4, 2'd0, 2'd2, 2'd0, 8'h50));
        send(32'h4500_0000, r);
        check("R4 R8 all disabled miss", r, {1'b1, 2'b00, 2'd0, 32'd0});
        send(32'h1234_5678, r);
        check("R4 unmapped miss", r, {1'b1, 2'b00, 2'd0, 32'd0});
    endtask

    task automatic t_backpressure;
        logic [36:0] ea;
        logic [36:0] eb;
        ea = model(32'hA000_0004);
        eb = model(32'h99AE_37F0);
        @(negedge clk);
        rsp_ready = 1'b0; req_addr = 32'hA000_0004; req_valid = 1'b1;
        @(negedge clk);
        req_addr = 32'h99AE_37F0;
        check("R9 answered next cycle", {36'd0, rsp_valid}, 37'd1);
        check("R10 stalled ready low", {36'd0, req_ready}, 37'd0);
        repeat (2) @(negedge clk);
        check("R9 held under stall", {rsp_err, rsp_ctrl_sel, rsp_space, rsp_paddr}, ea);
        rsp_ready = 1'b1;
        #1;
        check("R10 ready follows drain", {36'd0, req_ready}, 37'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 second response", {rsp_err, rsp_ctrl_sel, rsp_space, rsp_paddr}, eb);
        @(negedge clk);
        check("R9 valid drops when taken", {36'd0, rsp_valid}, 37'd0);
    endtask

    task automatic t_write_timing;
        logic [36:0] r;
        logic [36:0] old_e;
        old_e = model(32'hA800_0000);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'd1; cfg_wdata = mk(8'hA0, 3'd4, 2'd0, 2'd3, 2'd1, 8'h70);
        req_addr = 32'hA800_0000; req_valid = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        r = {rsp_err, rsp_ctrl_sel, rsp_space, rsp_paddr};
        check("R11 same-edge uses old", r, old_e);
        shadow[1] = mk(8'hA0, 3'd4, 2'd0, 2'd3, 2'd1, 8'h70);
        send(32'hA800_0000, r);
        check("R11 R12 later uses new", r, {1'b0, 2'b01, 2'd3, 32'h7800_0000});
    endtask

    initial begin
        for (int k = 0; k < 4; k++) shadow[k] = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_example();
        t_granule();
        t_priority();
        t_backpressure();
        t_write_timing();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule